// File: doc/BRIEF.md
# Tick Compare Timer Interrupt Unit

This block keeps a free-running 63-bit tick counter and two compare channels. One channel is privileged and the other is for the hypervisor. Each compare register is 64 bits wide. Its top bit turns interrupts off for that channel, and its low 63 bits hold the tick value to wait for. When the counter reaches the value of an enabled, armed channel, that channel fires once. A privileged match produces a one-cycle request that software-interrupt bit 16 be set. A hypervisor match sets a sticky pending flag, and that flag drives the hypervisor interrupt line.

Software loads the two compare registers and the pending flag through one write port. A channel is armed only at the moment of a write, and only if the new target lies strictly ahead of the count seen in that write cycle. Every write to a channel replaces whatever match the old value had scheduled. The block does not hold the software-interrupt register, does not mask interrupts and does not deliver traps. It only produces the set request and the pending line.

Top module: `tick_cmp_timer`

## Requirements
- R1: While `rst_n` is low at a clock edge, the counter is cleared to 0, the pending flag is cleared, and both compare registers take the value 0x8000_0000_0000_0000, so both channels start disabled.
- R2: The counter `tick_count` increases by one on every clock edge outside reset and wraps modulo 2^63.
- R3: A write takes effect at the clock edge where `wr_en` is high. The value of `wr_sel` picks the target: 2'b00 is the privileged compare, 2'b01 the hypervisor compare, 2'b10 the pending flag (from `wr_data[0]`), and 2'b11 changes nothing. A written compare value appears on `priv_cmp` or `hyp_cmp` from the next cycle on.
- R4: An armed privileged channel raises `softint16_set` for exactly one cycle: the cycle in which `tick_count` equals `priv_cmp[62:0]`.
- R5: A compare value written with bit 63 set never produces a match on its channel.
- R6: A compare value whose bits 62:0 are at or below `tick_count` in the write cycle produces no match, including the match that would otherwise come after the counter wraps.
- R7: Writing a compare register cancels any match its previous value would have produced, and a write to a channel in the very cycle of its match suppresses that match.
- R8: A hypervisor match sets the pending flag. `hyp_irq` goes high in the cycle after the match and stays high until software clears the flag.
- R9: Writing the pending flag with `wr_data[0]`=0 drops `hyp_irq` from the next cycle, and writing it with 1 raises it. A hypervisor match in the same cycle as a clearing write wins, so the flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 00 privileged compare, 01 hypervisor compare, 10 pending flag, 11 none |
| wr_data | input | 64 | Write data |
| tick_count | output | 63 | Current counter value |
| priv_cmp | output | 64 | Privileged compare register (bit 63 = disable) |
| hyp_cmp | output | 64 | Hypervisor compare register (bit 63 = disable) |
| softint16_set | output | 1 | One-cycle request to set software-interrupt bit 16 |
| hyp_irq | output | 1 | Hypervisor interrupt line, high while the pending flag is set |

## Verification
Each channel is given a target several ticks ahead, a target one tick ahead, a target equal to the count and a target behind it. This separates a strict greater-than arming test from a greater-or-equal one and from an equality test without arming. The same targets are also written with the disable bit set, which shows whether bit 63 is honoured or treated as part of the match. Rewrites are placed before the match and in the match cycle itself, so that a stale or double firing can be seen. Hypervisor matches are combined with clearing writes to the pending flag, placed both apart from the match and in the same cycle, and this exposes the sticky behaviour and the priority between set and clear.

// File: rtl/tick_cmp_pkg.sv
// Package: tick_cmp_pkg
// Shared encodings for the tick compare timer. It holds the write-target
// selector and the channel indices used to index the generated compare
// channels.
package tick_cmp_pkg;

    typedef enum logic [1:0] {
        SEL_PRIV_CMP = 2'b00,
        SEL_HYP_CMP  = 2'b01,
        SEL_PEND     = 2'b10,
        SEL_NONE     = 2'b11
    } wr_target_e;

    localparam int unsigned CH_PRIV = 0;
    localparam int unsigned CH_HYP  = 1;
    localparam int unsigned NUM_CH  = 2;

endpackage

// File: rtl/tick_counter.sv
// Module: tick_counter
// A free-running up-counter that steps by one on every clock and wraps at
// 2^TICK_W. It assumes a synchronous active-low reset that clears it to 0.
module tick_counter #(
    parameter int unsigned TICK_W = 63
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [TICK_W-1:0] count
);

    localparam logic [TICK_W-1:0] ONE = {{(TICK_W-1){1'b0}}, 1'b1};

    logic [TICK_W-1:0] count_q;

    // Purpose: advance the tick by one each cycle; the carry out is dropped
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else begin
            count_q <= count_q + ONE;
        end
    end

    assign count = count_q;

    // R2: the counter advances by exactly one per clock
    a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (count_q == $past(count_q) + ONE));

endmodule

// File: rtl/tick_cmp_channel.sv
// Module: tick_cmp_channel
// One compare channel. It holds a TICK_W+1 bit register whose top bit is a
// disable flag. A write arms the channel only if the new target lies strictly
// ahead of the current count and the channel is enabled. An armed channel
// fires for one cycle when the count equals the target, and then disarms.
// It assumes that the count passed in steps by exactly one per clock.
module tick_cmp_channel #(
    parameter int unsigned TICK_W = 63
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [TICK_W:0]   load_val,
    input  logic [TICK_W-1:0] count,
    output logic [TICK_W:0]   cmp,
    output logic              fire
);

    localparam int unsigned   DIS_BIT   = TICK_W;
    localparam logic [TICK_W:0] CMP_RST = {1'b1, {TICK_W{1'b0}}};

    logic [TICK_W:0]   cmp_q;
    logic              armed_q;
    logic [TICK_W-1:0] target;
    logic              ahead;
    logic              hit;

    assign target = cmp_q[TICK_W-1:0];
    assign ahead  = (load_val[TICK_W-1:0] > count);
    assign hit    = (count == target);

    // Purpose: store the compare value written by software
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_q <= CMP_RST;
        end else if (load) begin
            cmp_q <= load_val;
        end
    end

    // Purpose: arm on an enabled write that is strictly ahead; disarm after firing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
        end else if (load) begin
            armed_q <= !load_val[DIS_BIT] && ahead;
        end else if (fire) begin
            armed_q <= 1'b0;
        end
    end

    // Purpose: one-cycle match pulse; a write in the same cycle cancels it
    always_comb begin
        fire = armed_q && hit && !load && !cmp_q[DIS_BIT];
    end

    assign cmp = cmp_q;

    // R4: a firing happens only when the count equals the stored target
    a_r4_fire_on_match: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> (count == cmp_q[TICK_W-1:0]));

    // R4: the pulse lasts a single cycle
    a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> !fire);

    // R5: a disabled register never fires
    a_r5_disabled_silent: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_q[DIS_BIT] |-> !fire);

    // R6: a target at or behind the count leaves the channel unarmed
    a_r6_behind_not_armed: assert property (@(posedge clk) disable iff (!rst_n)
        (load && (load_val[TICK_W-1:0] <= count)) |=> !armed_q);

    // R7: a write in the match cycle suppresses that match
    a_r7_write_suppresses: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !fire);

endmodule

// File: rtl/hyp_pend_flag.sv
// Module: hyp_pend_flag
// The sticky hypervisor-pending flag. A match sets it. A software write
// loads it from the data bit. When both happen in one cycle, the match wins.
// The interrupt line is the registered flag itself.
module hyp_pend_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic wr_i,
    input  logic wr_val_i,
    output logic pend_o
);

    logic pend_q;

    // Purpose: hold the pending state; a hardware set takes priority over a write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (set_i) begin
            pend_q <= 1'b1;
        end else if (wr_i) begin
            pend_q <= wr_val_i;
        end
    end

    assign pend_o = pend_q;

    // R8: the flag rises only after a match or a write of one
    a_r8_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend_q) |-> $past(set_i || (wr_i && wr_val_i)));

    // R9: a clearing write with no match drops the flag
    a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !wr_val_i && !set_i) |=> !pend_q);

    // R9: a match wins over a simultaneous clear
    a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> pend_q);

endmodule

// File: rtl/tick_cmp_timer.sv
// Module: tick_cmp_timer
// Top of the tick compare timer. It combines the tick counter, the two
// compare channels (built by a generate loop) and the hypervisor pending
// flag. Writes are decoded from wr_sel. The privileged channel's pulse leaves
// the block as the softint bit-16 set request. The hypervisor channel's pulse
// sets the pending flag. It assumes that one write target is selected per cycle.
module tick_cmp_timer
    import tick_cmp_pkg::*;
#(
    parameter int unsigned TICK_W = 63
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [TICK_W:0]   wr_data,
    output logic [TICK_W-1:0] tick_count,
    output logic [TICK_W:0]   priv_cmp,
    output logic [TICK_W:0]   hyp_cmp,
    output logic              softint16_set,
    output logic              hyp_irq
);

    localparam int unsigned CMP_W = TICK_W + 1;

    wr_target_e         sel;
    logic [NUM_CH-1:0]  ch_load;
    logic [NUM_CH-1:0]  ch_fire;
    logic [CMP_W-1:0]   ch_cmp [NUM_CH];
    logic               pend_wr;
    logic [TICK_W-1:0]  count;

    assign sel = wr_target_e'(wr_sel);

    // Purpose: decode the single write port into per-target strobes
    always_comb begin
        ch_load          = '0;
        pend_wr          = 1'b0;
        ch_load[CH_PRIV] = wr_en && (sel == SEL_PRIV_CMP);
        ch_load[CH_HYP]  = wr_en && (sel == SEL_HYP_CMP);
        pend_wr          = wr_en && (sel == SEL_PEND);
    end

    tick_counter #(.TICK_W(TICK_W)) u_counter (
        .clk   (clk),
        .rst_n (rst_n),
        .count (count)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        tick_cmp_channel #(.TICK_W(TICK_W)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (ch_load[g]),
            .load_val (wr_data),
            .count    (count),
            .cmp      (ch_cmp[g]),
            .fire     (ch_fire[g])
        );
    end

    hyp_pend_flag u_pend (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (ch_fire[CH_HYP]),
        .wr_i     (pend_wr),
        .wr_val_i (wr_data[0]),
        .pend_o   (hyp_irq)
    );

    assign tick_count    = count;
    assign priv_cmp      = ch_cmp[CH_PRIV];
    assign hyp_cmp       = ch_cmp[CH_HYP];
    assign softint16_set = ch_fire[CH_PRIV];

    // R3: the no-target selector leaves both compare registers unchanged
    a_r3_none_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (sel == SEL_NONE)) |=> ($stable(priv_cmp) && $stable(hyp_cmp)));

    // R3: a compare write shows up on its register output next cycle
    a_r3_priv_load: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (sel == SEL_PRIV_CMP)) |=> (priv_cmp == $past(wr_data)));

endmodule

// File: tb/tick_cmp_timer_tb.sv
module tick_cmp_timer_tb;

    localparam int TW = 63;

    typedef struct {
        int          kind;   // 0: softint16_set pulse, 1: hyp_irq rise
        logic [TW-1:0] cnt;  // tick_count value expected when observed
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_sel = 2'b11;
    logic [TW:0]   wr_data = '0;
    logic [TW-1:0] tick_count;
    logic [TW:0]   priv_cmp;
    logic [TW:0]   hyp_cmp;
    logic          softint16_set;
    logic          hyp_irq;

    int   n_tests = 0;
    int   n_fail  = 0;
    bit   done    = 0;
    logic prev_irq = 1'b0;
    exp_t q[$];

    always #2 clk = ~clk;

    tick_cmp_timer #(.TICK_W(TW)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .tick_count(tick_count), .priv_cmp(priv_cmp),
        .hyp_cmp(hyp_cmp), .softint16_set(softint16_set), .hyp_irq(hyp_irq)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic push_exp(input int kind, input logic [TW-1:0] cnt);
        exp_t e;
        int   pos;
        e.kind = kind;
        e.cnt  = cnt;
        pos = q.size();
        for (int i = 0; i < q.size(); i++) begin
            if (q[i].cnt > cnt) begin
                pos = i;
                break;
            end
        end
        q.insert(pos, e);
    endtask

    task automatic drop_kind(input int kind);
        for (int i = q.size() - 1; i >= 0; i--) begin
            if (q[i].kind == kind) q.delete(i);
        end
    endtask

    // Driver: called at posedge+1; drives one write and records expectations
    task automatic wr(input logic [1:0] sel, input logic [TW:0] d);
        logic [TW-1:0] cur;
        cur = tick_count;
        if (sel == 2'b00) begin
            drop_kind(0);
            if (!d[TW] && d[TW-1:0] > cur) push_exp(0, d[TW-1:0]);
        end else if (sel == 2'b01) begin
            drop_kind(1);
            if (!d[TW] && d[TW-1:0] > cur && !hyp_irq) push_exp(1, d[TW-1:0] + 1);
        end else if (sel == 2'b10) begin
            if (d[0] && !hyp_irq) push_exp(1, cur + 1);
        end
        wr_en   = 1'b1;
        wr_sel  = sel;
        wr_data = d;
        @(posedge clk);
        #1;
        wr_en   = 1'b0;
        wr_sel  = 2'b11;
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic drained(input string req);
        chk(q.size() == 0, req, "expected events still outstanding",
            64'(q.size()), 64'd0);
    endtask

    function automatic logic [TW:0] en(input logic [TW-1:0] v);
        return {1'b0, v};
    endfunction

    function automatic logic [TW:0] dis(input logic [TW-1:0] v);
        return {1'b1, v};
    endfunction

    // Monitor: pops expected events and compares them at the falling edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (softint16_set) begin
                if (q.size() == 0) begin
                    chk(1'b0, "R4", "unexpected softint16_set at count", 64'(tick_count), 64'd0);
                end else begin
                    chk(q[0].kind == 0 && q[0].cnt == tick_count, "R4",
                        "softint16_set pulse count", 64'(tick_count), 64'(q[0].cnt));
                    void'(q.pop_front());
                end
            end
            if (hyp_irq && !prev_irq) begin
                if (q.size() == 0) begin
                    chk(1'b0, "R8", "unexpected hyp_irq rise at count", 64'(tick_count), 64'd0);
                end else begin
                    chk(q[0].kind == 1 && q[0].cnt == tick_count, "R8",
                        "hyp_irq rise count", 64'(tick_count), 64'(q[0].cnt));
                    void'(q.pop_front());
                end
            end
            prev_irq <= hyp_irq;
        end
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog: run did not finish, actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [TW-1:0] c;
        logic [TW:0]   keep_p;
        logic [TW:0]   keep_h;

        // R1: reset state
        idle(3);
        chk(tick_count == '0, "R1", "tick_count in reset", 64'(tick_count), 64'd0);
        chk(priv_cmp == dis('0), "R1", "priv_cmp in reset", priv_cmp, dis('0));
        chk(hyp_cmp == dis('0), "R1", "hyp_cmp in reset", hyp_cmp, dis('0));
        chk(!hyp_irq && !softint16_set, "R1", "outputs in reset",
            {62'd0, hyp_irq, softint16_set}, 64'd0);
        rst_n = 1'b1;
        idle(1);

        // R2: counter step
        c = tick_count;
        idle(10);
        chk(tick_count == c + 10, "R2", "count after 10 clocks", 64'(tick_count), 64'(c + 10));

        // R4 and R3: privileged match several ticks ahead
        c = tick_count;
        wr(2'b00, en(c + 6));
        chk(priv_cmp == en(c + 6), "R3", "priv_cmp readback", priv_cmp, en(c + 6));
        idle(10);
        drained("R4");

        // R4: target one tick ahead
        c = tick_count;
        wr(2'b00, en(c + 1));
        idle(4);
        drained("R4");

        // R5: disabled target ahead gives nothing
        c = tick_count;
        wr(2'b00, dis(c + 4));
        wr(2'b01, dis(c + 5));
        idle(10);
        drained("R5");
        chk(!hyp_irq, "R5", "hyp_irq after disabled hyp target", 64'(hyp_irq), 64'd0);

        // R6: target equal to and behind the count
        c = tick_count;
        wr(2'b00, en(c));
        idle(4);
        c = tick_count;
        wr(2'b00, en(c - 3));
        c = tick_count;
        wr(2'b01, en(c));
        idle(8);
        drained("R6");
        chk(!hyp_irq, "R6", "hyp_irq after target at count", 64'(hyp_irq), 64'd0);

        // R7: rewrite before match moves it
        c = tick_count;
        wr(2'b00, en(c + 10));
        idle(2);
        wr(2'b00, en(c + 20));
        idle(25);
        drained("R7");

        // R7: write in the exact match cycle suppresses it
        c = tick_count;
        wr(2'b00, en(c + 4));
        idle(3);
        chk(tick_count == c + 4, "R7", "positioned at match cycle", 64'(tick_count), 64'(c + 4));
        wr(2'b00, en(c + 4));
        idle(6);
        drained("R7");

        // R8: hypervisor match sets sticky flag
        c = tick_count;
        wr(2'b01, en(c + 5));
        idle(30);
        drained("R8");
        chk(hyp_irq, "R8", "hyp_irq stays high", 64'(hyp_irq), 64'd1);

        // R9: clearing write drops the line
        wr(2'b10, 64'd0);
        chk(!hyp_irq, "R9", "hyp_irq after clear", 64'(hyp_irq), 64'd0);
        idle(1);

        // R9: software set and clear
        wr(2'b10, 64'd1);
        idle(2);
        chk(hyp_irq, "R9", "hyp_irq after software set", 64'(hyp_irq), 64'd1);
        wr(2'b10, 64'd0);
        chk(!hyp_irq, "R9", "hyp_irq after second clear", 64'(hyp_irq), 64'd0);
        idle(2);
        drained("R9");

        // R9: match wins over a clear in the same cycle
        c = tick_count;
        wr(2'b01, en(c + 4));
        idle(3);
        chk(tick_count == c + 4, "R9", "positioned at hyp match cycle", 64'(tick_count), 64'(c + 4));
        wr(2'b10, 64'd0);
        chk(hyp_irq, "R9", "hyp_irq after match with clear", 64'(hyp_irq), 64'd1);
        idle(3);
        drained("R9");
        wr(2'b10, 64'd0);
        idle(2);

        // R4 and R8: both channels on one target
        c = tick_count;
        wr(2'b00, en(c + 8));
        wr(2'b01, en(c + 8));
        idle(12);
        drained("R8");
        wr(2'b10, 64'd0);

        // R3: selector 11 changes nothing
        keep_p = priv_cmp;
        keep_h = hyp_cmp;
        wr(2'b11, {1'b0, 63'h1234});
        idle(1);
        chk(priv_cmp == keep_p, "R3", "priv_cmp after sel 11", priv_cmp, keep_p);
        chk(hyp_cmp == keep_h, "R3", "hyp_cmp after sel 11", hyp_cmp, keep_h);
        chk(!hyp_irq, "R3", "hyp_irq after sel 11", 64'(hyp_irq), 64'd0);
        idle(4);
        drained("R3");

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule